// File: doc/BRIEF.md
# Data-Move Instruction Executor for a 16-bit DSP

This block carries out the load and store instructions of a small 16-bit signal processor. The fetch stage hands it one instruction word. If the encoding needs a second word, the block asks the fetch stage for that word. It then performs exactly one memory access: a data-memory read, a data-memory write, or an instruction-memory read. After the access it writes the loaded value into the register file and, where the mode calls for it, writes a post-modified pointer back. It reports completion with a one-cycle `done` pulse.

Data memory can be addressed in four ways:
- a paged form, where the high byte comes from a configuration register and the low byte from the instruction;
- a full 16-bit address carried in an extension word;
- a sign-extended 8-bit field, used by store-immediate;
- one of four pointer registers.

Pointer modes can leave the pointer unchanged, step it down by one, step it up by one, or add its paired signed index register to it. Stores taken from the two accumulator middle registers (numbers 0x1E and 0x1F) are clamped when the whole 40-bit accumulator does not fit in signed 32 bits.

The controller has three states:
- `S_IDLE` accepts an instruction when `instr_valid` is high. It moves to `S_FETCH_EXT` for a two-word encoding and to `S_EXEC` otherwise.
- `S_FETCH_EXT` holds `fetch_next` high and waits. When `ext_valid` arrives it moves to `S_EXEC`.
- `S_EXEC` performs the access, pulses `done` and always returns to `S_IDLE`.

`instr_valid` is only looked at in `S_IDLE`. Register reads are combinational: the block drives `src_sel` and `ptr_sel`, and the register file returns the values in the same cycle. Memory reads are also combinational.

Top module: `ldst_exec`

## Requirements
- R1: After reset `done`, `fetch_next`, `dm_re`, `dm_we`, `im_re`, `rf_we` and `ar_we` are all low.
- R2: Encodings `0010 Lrrr iiii iiii` are paged accesses. L=0 loads and L=1 stores. The register is 0x18 plus `rrr`. The address is `{cr_val[7:0], iiii iiii}`.
- R3: Encodings `0000 0000 11Lr rrrr` are direct accesses (L=1 stores) to register `rrrrr`. They raise `fetch_next` in the cycle after acceptance and keep it high until `ext_valid`. The extension word is the address, and `done` follows one cycle after `ext_valid`.
- R4: Encoding `0001 0110 aaaa aaaa` writes the extension word to data memory. The address is the 8-bit field sign-extended to 16 bits.
- R5: Encodings `0001 10Lm mppr rrrr` are pointer accesses (L=1 stores) through pointer `pp` to register `rrrrr`. The memory address is the pointer value from before any update.
- R6: The mode field `mm` (bits [8:7] in pointer accesses, bits [3:2] in instruction-memory loads) selects one of four updates: 00 leaves the pointer unchanged, 01 subtracts one, 10 adds one, and 11 adds the paired index register (register 4+`pp`). All arithmetic wraps modulo 2^16. The new value goes out on `ar_we`/`ar_wsel`/`ar_wdata` in the `done` cycle, and `ar_we` stays low for mode 00.
- R7: A store whose source register is 0x1E or 0x1F writes the middle word unchanged when `src_acc_hi` equals 8 copies of its bit 15. Otherwise it writes 0x7FFF when `src_acc_hi` bit 7 is 0 and 0x8000 when it is 1.
- R8: Encodings `0000 001d 0001 mmpp` read instruction memory at pointer `pp` and load the result into register 0x1E+`d`.
- R9: Every register write to 0x1E or 0x1F raises `rf_ext` so that the register file applies its conditional sign extension. Writes to other registers leave it low.
- R10: One-word instructions, including unrecognised encodings, pulse `done` exactly one cycle after acceptance. An unrecognised encoding performs no memory access and no register write.
- R11: At most one of `dm_re`, `dm_we`, `im_re` is high at a time, and only in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered (sampled in S_IDLE) |
| instr | input | 16 | Instruction word |
| fetch_next | output | 1 | Request for the extension word |
| ext_valid | input | 1 | Extension word present |
| ext_word | input | 16 | Extension word |
| done | output | 1 | Completion pulse |
| cr_val | input | 16 | Page configuration register |
| ptr_sel | output | 2 | Selected pointer register |
| ptr_val | input | 16 | Value of selected pointer |
| idx_val | input | 16 | Value of the index paired with the pointer |
| src_sel | output | 5 | Register number to read for stores |
| src_val | input | 16 | Value of `src_sel` |
| src_acc_hi | input | 8 | High byte of the accumulator holding `src_sel` |
| dm_addr | output | 16 | Data-memory address |
| dm_re | output | 1 | Data-memory read strobe |
| dm_we | output | 1 | Data-memory write strobe |
| dm_wdata | output | 16 | Data-memory write data |
| dm_rdata | input | 16 | Data-memory read data |
| im_addr | output | 16 | Instruction-memory address |
| im_re | output | 1 | Instruction-memory read strobe |
| im_rdata | input | 16 | Instruction-memory read data |
| rf_we | output | 1 | Register write enable |
| rf_wsel | output | 5 | Register written |
| rf_wdata | output | 16 | Register write data |
| rf_ext | output | 1 | Apply accumulator sign extension |
| ar_we | output | 1 | Pointer write-back enable |
| ar_wsel | output | 2 | Pointer written back |
| ar_wdata | output | 16 | Updated pointer value |

## Verification
The hardest cases to reach are the pointer updates at the edges of the 16-bit range. These are a decrement from 0x0000, an increment from 0xFFFF, and an index of 0xFFFE treated as -2. Each must show the old value on the memory address while the wrapped value appears on the pointer write-back in the same cycle.

The bench reaches these cases by preloading its register model with those edge values before each pointer instruction. It gets to the saturation branches the same way, by setting the accumulator high byte on either side of the sign-copy condition. The direct forms are run with the extension word held back for several cycles, so that the request hold and the one-cycle completion after arrival are both seen.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int DW      = 16;
    localparam int RSW     = 5;
    localparam int PW      = 2;
    localparam int HIW     = 8;
    localparam int IMMW    = 8;
    localparam logic [RSW-1:0] PAGE_BASE = 5'h18;
    localparam logic [RSW-1:0] MID_BASE  = 5'h1E;

    typedef enum logic [2:0] {
        K_NOP, K_LOAD_D, K_STORE_D, K_STORE_IMM, K_LOAD_I
    } kind_t;

    typedef enum logic [1:0] {A_PAGE, A_EXT, A_SIMM, A_PTR} asrc_t;

    typedef enum logic [1:0] {PM_KEEP, PM_DEC, PM_INC, PM_IDX} pmod_t;

    typedef struct packed {
        kind_t           kind;
        asrc_t           asrc;
        pmod_t           pmod;
        logic [RSW-1:0]  rsel;
        logic [PW-1:0]   ptr;
        logic [IMMW-1:0] imm8;
        logic            two_word;
    } dec_t;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [DW-1:0] word,
    output dec_t          d
);
    always_comb begin
        d          = '0;
        d.kind     = K_NOP;
        d.asrc     = A_PAGE;
        d.pmod     = PM_KEEP;
        d.imm8     = word[IMMW-1:0];
        if (word[15:12] == 4'b0010) begin
            d.kind = word[11] ? K_STORE_D : K_LOAD_D;
            d.asrc = A_PAGE;
            d.rsel = PAGE_BASE + {2'b00, word[10:8]};
        end else if (word[15:6] == 10'b0000_0000_11) begin
            d.kind     = word[5] ? K_STORE_D : K_LOAD_D;
            d.asrc     = A_EXT;
            d.rsel     = word[4:0];
            d.two_word = 1'b1;
        end else if (word[15:8] == 8'h16) begin
            d.kind     = K_STORE_IMM;
            d.asrc     = A_SIMM;
            d.two_word = 1'b1;
        end else if (word[15:10] == 6'b000110) begin
            d.kind = word[9] ? K_STORE_D : K_LOAD_D;
            d.asrc = A_PTR;
            d.pmod = pmod_t'(word[8:7]);
            d.ptr  = word[6:5];
            d.rsel = word[4:0];
        end else if (word[15:9] == 7'b0000001 && word[7:4] == 4'b0001) begin
            d.kind = K_LOAD_I;
            d.asrc = A_PTR;
            d.pmod = pmod_t'(word[3:2]);
            d.ptr  = word[1:0];
            d.rsel = MID_BASE + {4'b0000, word[8]};
        end
    end
endmodule

// File: rtl/ldst_sat.sv
module ldst_sat #(
    parameter int W  = 16,
    parameter int HW = 8
) (
    input  logic [W-1:0]  mid,
    input  logic [HW-1:0] hi,
    output logic [W-1:0]  out
);
    logic fits;
    assign fits = (hi == {HW{mid[W-1]}});
    always_comb begin
        if (fits)           out = mid;
        else if (hi[HW-1])  out = {1'b1, {(W-1){1'b0}}};
        else                out = {1'b0, {(W-1){1'b1}}};
    end
endmodule

// File: rtl/ldst_postmod.sv
module ldst_postmod
    import ldst_pkg::*;
#(
    parameter int W = 16
) (
    input  pmod_t         mode,
    input  logic [W-1:0]  base,
    input  logic [W-1:0]  idx,
    output logic [W-1:0]  next
);
    always_comb begin
        unique case (mode)
            PM_KEEP: next = base;
            PM_DEC:  next = base - W'(1);
            PM_INC:  next = base + W'(1);
            PM_IDX:  next = base + idx;
            default: next = base;
        endcase
    end
endmodule

// File: rtl/ldst_exec.sv
module ldst_exec
    import ldst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [DW-1:0]   instr,
    output logic            fetch_next,
    input  logic            ext_valid,
    input  logic [DW-1:0]   ext_word,
    output logic            done,
    input  logic [DW-1:0]   cr_val,
    output logic [PW-1:0]   ptr_sel,
    input  logic [DW-1:0]   ptr_val,
    input  logic [DW-1:0]   idx_val,
    output logic [RSW-1:0]  src_sel,
    input  logic [DW-1:0]   src_val,
    input  logic [HIW-1:0]  src_acc_hi,
    output logic [DW-1:0]   dm_addr,
    output logic            dm_re,
    output logic            dm_we,
    output logic [DW-1:0]   dm_wdata,
    input  logic [DW-1:0]   dm_rdata,
    output logic [DW-1:0]   im_addr,
    output logic            im_re,
    input  logic [DW-1:0]   im_rdata,
    output logic            rf_we,
    output logic [RSW-1:0]  rf_wsel,
    output logic [DW-1:0]   rf_wdata,
    output logic            rf_ext,
    output logic            ar_we,
    output logic [PW-1:0]   ar_wsel,
    output logic [DW-1:0]   ar_wdata
);
    typedef enum logic [1:0] {S_IDLE, S_FETCH_EXT, S_EXEC} state_t;

    state_t        st;
    dec_t          dec_in;
    dec_t          cur;
    logic [DW-1:0] ext_q;
    logic [DW-1:0] sat_val;
    logic [DW-1:0] ptr_next;
    logic          src_is_mid;
    logic          in_exec;

    ldst_decode u_dec (.word(instr), .d(dec_in));

    ldst_sat #(.W(DW), .HW(HIW)) u_sat (.mid(src_val), .hi(src_acc_hi), .out(sat_val));

    ldst_postmod #(.W(DW)) u_pm (.mode(cur.pmod), .base(ptr_val), .idx(idx_val), .next(ptr_next));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cur   <= '0;
            ext_q <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (instr_valid) begin
                    cur <= dec_in;
                    st  <= dec_in.two_word ? S_FETCH_EXT : S_EXEC;
                end
                S_FETCH_EXT: if (ext_valid) begin
                    ext_q <= ext_word;
                    st    <= S_EXEC;
                end
                S_EXEC:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign in_exec    = (st == S_EXEC);
    assign src_is_mid = (cur.rsel >= MID_BASE);
    assign ptr_sel    = cur.ptr;
    assign src_sel    = cur.rsel;
    assign im_addr    = ptr_val;
    assign rf_wsel    = cur.rsel;
    assign ar_wsel    = cur.ptr;
    assign ar_wdata   = ptr_next;

    // outputs
    always_comb begin
        fetch_next = (st == S_FETCH_EXT);
        done       = in_exec;
        dm_re      = 1'b0;
        dm_we      = 1'b0;
        im_re      = 1'b0;
        rf_we      = 1'b0;
        rf_wdata   = '0;
        ar_we      = 1'b0;
        unique case (cur.asrc)
            A_PAGE:  dm_addr = {cr_val[7:0], cur.imm8};
            A_EXT:   dm_addr = ext_q;
            A_SIMM:  dm_addr = {{(DW-IMMW){cur.imm8[IMMW-1]}}, cur.imm8};
            A_PTR:   dm_addr = ptr_val;
            default: dm_addr = ptr_val;
        endcase
        if (cur.kind == K_STORE_IMM) dm_wdata = ext_q;
        else if (src_is_mid)         dm_wdata = sat_val;
        else                         dm_wdata = src_val;
        if (in_exec) begin
            unique case (cur.kind)
                K_LOAD_D: begin
                    dm_re    = 1'b1;
                    rf_we    = 1'b1;
                    rf_wdata = dm_rdata;
                end
                K_STORE_D, K_STORE_IMM: dm_we = 1'b1;
                K_LOAD_I: begin
                    im_re    = 1'b1;
                    rf_we    = 1'b1;
                    rf_wdata = im_rdata;
                end
                default: ;
            endcase
            ar_we = (cur.kind != K_NOP) && (cur.asrc == A_PTR) && (cur.pmod != PM_KEEP);
        end
        rf_ext = rf_we && src_is_mid;
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_re || dm_we || im_re) |-> (done && $onehot0({dm_re, dm_we, im_re}))); // R11

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_next && !ext_valid) |=> fetch_next); // R3

    AST_EXT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_next && ext_valid) |=> done); // R3

    AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && instr_valid && !dec_in.two_word) |=> (done && !fetch_next)); // R10

    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_we && src_sel >= MID_BASE && cur.kind != K_STORE_IMM
         && src_acc_hi != {HIW{src_val[DW-1]}})
        |-> (dm_wdata == 16'h7FFF || dm_wdata == 16'h8000)); // R7

    AST_PTR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ar_we |-> done); // R6

    AST_EXT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rf_ext |-> (rf_we && rf_wsel >= MID_BASE)); // R9
endmodule

// File: tb/tb_ldst_exec.sv
module tb_ldst_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        fetch_next;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic        done;
    logic [15:0] cr_val;
    logic [1:0]  ptr_sel;
    logic [15:0] ptr_val, idx_val;
    logic [4:0]  src_sel;
    logic [15:0] src_val;
    logic [7:0]  src_acc_hi;
    logic [15:0] dm_addr, dm_wdata, dm_rdata, im_addr, im_rdata;
    logic        dm_re, dm_we, im_re;
    logic        rf_we, rf_ext, ar_we;
    logic [4:0]  rf_wsel;
    logic [15:0] rf_wdata, ar_wdata;
    logic [1:0]  ar_wsel;

    logic [15:0] regs [32];
    logic [7:0]  hi0, hi1;

    assign cr_val     = regs[5'h13];
    assign ptr_val    = regs[{3'b000, ptr_sel}];
    assign idx_val    = regs[{3'b001, ptr_sel}];
    assign src_val    = regs[src_sel];
    assign src_acc_hi = src_sel[0] ? hi1 : hi0;
    assign dm_rdata   = dm_addr ^ 16'hA55A;
    assign im_rdata   = im_addr + 16'h1234;

    ldst_exec dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] c_dm_addr, c_dm_wdata, c_im_addr, c_rf_wdata, c_ar_wdata;
    logic        c_dm_re, c_dm_we, c_im_re, c_rf_we, c_rf_ext, c_ar_we;
    logic [4:0]  c_rf_wsel;
    logic [1:0]  c_ar_wsel;
    int          lat, ext_at, fn_cnt;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] ins, input logic [15:0] ext, input int delay);
        int n = 0;
        int fn = 0;
        bit got = 0;
        ext_at = -1;
        @(negedge clk);
        instr = ins;
        instr_valid = 1'b1;
        while (!got && n < 20) begin
            @(negedge clk);
            instr_valid = 1'b0;
            ext_valid = 1'b0;
            n++;
            if (done) begin
                got = 1; lat = n;
                c_dm_addr = dm_addr; c_dm_wdata = dm_wdata; c_dm_re = dm_re; c_dm_we = dm_we;
                c_im_addr = im_addr; c_im_re = im_re;
                c_rf_we = rf_we; c_rf_wsel = rf_wsel; c_rf_wdata = rf_wdata; c_rf_ext = rf_ext;
                c_ar_we = ar_we; c_ar_wsel = ar_wsel; c_ar_wdata = ar_wdata;
            end else if (fetch_next) begin
                fn++;
                if (fn > delay) begin
                    ext_valid = 1'b1;
                    ext_word = ext;
                    ext_at = n;
                end
            end
        end
        fn_cnt = fn;
        chk(got, "R10 done seen", 32'(got), 32'd1);
    endtask

    task automatic t_reset();
        chk(!done && !fetch_next, "R1 done/fetch_next idle", {done, fetch_next}, 0);
        chk(!dm_re && !dm_we && !im_re, "R1 memory strobes idle", {dm_re, dm_we, im_re}, 0);
        chk(!rf_we && !ar_we, "R1 write enables idle", {rf_we, ar_we}, 0);
    endtask

    task automatic t_paged();
        regs[5'h13] = 16'h12AB;
        run(16'h2305, 16'h0, 0);
        chk(lat == 1, "R2 paged load latency", lat, 1);
        chk(c_dm_re && !c_dm_we && c_dm_addr == 16'hAB05, "R2 paged load addr", c_dm_addr, 16'hAB05);
        chk(c_rf_we && c_rf_wsel == 5'h1B && c_rf_wdata == (16'hAB05 ^ 16'hA55A), "R2 paged load data",
            {c_rf_wsel, c_rf_wdata}, {5'h1B, 16'hAB05 ^ 16'hA55A});
        chk(!c_rf_ext, "R9 no extend for 0x1B", c_rf_ext, 0);
        regs[5'h1C] = 16'h5A5A;
        run(16'h2C7F, 16'h0, 0);
        chk(c_dm_we && !c_rf_we && c_dm_addr == 16'hAB7F && c_dm_wdata == 16'h5A5A, "R2 paged store",
            {c_dm_addr, c_dm_wdata}, {16'hAB7F, 16'h5A5A});
        run(16'h2610, 16'h0, 0);
        chk(c_rf_wsel == 5'h1E && c_rf_ext, "R9 extend for 0x1E load", {c_rf_wsel, c_rf_ext}, {5'h1E, 1'b1});
    endtask

    task automatic t_direct();
        run(16'h00C3, 16'h4321, 2);
        chk(fn_cnt == 3, "R3 fetch_next held while waiting", fn_cnt, 3);
        chk(lat == ext_at + 1, "R3 done one cycle after ext", lat, ext_at + 1);
        chk(c_dm_re && c_dm_addr == 16'h4321 && c_rf_wsel == 5'h03 && c_rf_wdata == (16'h4321 ^ 16'hA55A),
            "R3 direct load", {c_dm_addr, c_rf_wdata}, {16'h4321, 16'h4321 ^ 16'hA55A});
        regs[5] = 16'hC0DE;
        run(16'h00E5, 16'h0100, 0);
        chk(lat == 2 && c_dm_we && c_dm_addr == 16'h0100 && c_dm_wdata == 16'hC0DE, "R3 direct store",
            {c_dm_addr, c_dm_wdata}, {16'h0100, 16'hC0DE});
    endtask

    task automatic t_store_imm();
        run(16'h1680, 16'hBEEF, 1);
        chk(c_dm_we && c_dm_addr == 16'hFF80 && c_dm_wdata == 16'hBEEF, "R4 negative field",
            {c_dm_addr, c_dm_wdata}, {16'hFF80, 16'hBEEF});
        run(16'h167F, 16'h1357, 0);
        chk(c_dm_addr == 16'h007F && c_dm_wdata == 16'h1357, "R4 positive field",
            {c_dm_addr, c_dm_wdata}, {16'h007F, 16'h1357});
    endtask

    task automatic ptr_case(input bit store, input logic [1:0] m, input logic [1:0] p, input logic [4:0] r,
                            input logic [15:0] arv, input logic [15:0] ixv);
        logic [15:0] ins, exp_ar;
        regs[{3'b000, p}] = arv;
        regs[{3'b001, p}] = ixv;
        case (m)
            2'd0: exp_ar = arv;
            2'd1: exp_ar = arv - 16'd1;
            2'd2: exp_ar = arv + 16'd1;
            default: exp_ar = arv + ixv;
        endcase
        ins = (store ? 16'h1A00 : 16'h1800) | {7'd0, m, p, r};
        run(ins, 16'h0, 0);
        chk(c_dm_addr == arv && (store ? c_dm_we : c_dm_re), "R5 pre-update address", c_dm_addr, arv);
        if (store) chk(c_dm_wdata == regs[r], "R5 pointer store data", c_dm_wdata, regs[r]);
        else chk(c_rf_wsel == r && c_rf_wdata == (arv ^ 16'hA55A), "R5 pointer load data", c_rf_wdata, arv ^ 16'hA55A);
        chk(c_ar_we == (m != 2'd0), "R6 write-back enable", c_ar_we, m != 2'd0);
        if (m != 2'd0) chk(c_ar_wsel == p && c_ar_wdata == exp_ar, "R6 updated pointer",
                           {c_ar_wsel, c_ar_wdata}, {p, exp_ar});
    endtask

    task automatic t_pointer();
        regs[9] = 16'h0909;
        ptr_case(1'b0, 2'd0, 2'd1, 5'h09, 16'h2000, 16'h0004);
        ptr_case(1'b0, 2'd1, 2'd2, 5'h09, 16'h0000, 16'h0004);
        ptr_case(1'b0, 2'd2, 2'd3, 5'h0A, 16'hFFFF, 16'h0004);
        ptr_case(1'b0, 2'd3, 2'd0, 5'h0B, 16'h1000, 16'hFFFE);
        ptr_case(1'b1, 2'd0, 2'd3, 5'h09, 16'h3000, 16'h0002);
        ptr_case(1'b1, 2'd1, 2'd1, 5'h09, 16'h0000, 16'h0002);
        ptr_case(1'b1, 2'd2, 2'd0, 5'h09, 16'hFFFF, 16'h0002);
        ptr_case(1'b1, 2'd3, 2'd2, 5'h09, 16'hFFF0, 16'h0020);
    endtask

    task automatic sat_case(input logic [7:0] hi, input logic [15:0] mid, input logic [15:0] exp);
        hi0 = hi;
        regs[5'h1E] = mid;
        run(16'h00FE, 16'h0200, 0);
        chk(c_dm_we && c_dm_wdata == exp, "R7 saturated store", c_dm_wdata, exp);
    endtask

    task automatic t_sat();
        sat_case(8'h00, 16'h1234, 16'h1234);
        sat_case(8'h01, 16'h1234, 16'h7FFF);
        sat_case(8'hFF, 16'h1234, 16'h8000);
        sat_case(8'hFF, 16'h8001, 16'h8001);
        sat_case(8'h00, 16'h9000, 16'h7FFF);
        hi1 = 8'h80;
        regs[5'h1F] = 16'h0000;
        regs[1] = 16'h0040;
        run(16'h1A3F, 16'h0, 0);
        chk(c_dm_wdata == 16'h8000 && c_dm_addr == 16'h0040, "R7 pointer store from 0x1F", c_dm_wdata, 16'h8000);
    endtask

    task automatic t_imem();
        regs[2] = 16'h0100;
        regs[6] = 16'h0010;
        run(16'h021E, 16'h0, 0);
        chk(c_im_re && !c_dm_re && !c_dm_we && c_im_addr == 16'h0100, "R8 imem address", c_im_addr, 16'h0100);
        chk(c_rf_we && c_rf_wsel == 5'h1E && c_rf_wdata == 16'h1334, "R8 imem load target",
            {c_rf_wsel, c_rf_wdata}, {5'h1E, 16'h1334});
        chk(c_rf_ext, "R9 imem load extends", c_rf_ext, 1);
        chk(c_ar_we && c_ar_wsel == 2'd2 && c_ar_wdata == 16'h0110, "R6 imem index mode", c_ar_wdata, 16'h0110);
        regs[3] = 16'h0000;
        run(16'h0317, 16'h0, 0);
        chk(c_rf_wsel == 5'h1F && c_ar_wdata == 16'hFFFF && c_ar_we, "R8 imem d=1 decrement",
            {c_rf_wsel, c_ar_wdata}, {5'h1F, 16'hFFFF});
    endtask

    task automatic t_nop();
        run(16'h0000, 16'h0, 0);
        chk(lat == 1, "R10 unknown latency", lat, 1);
        chk(!c_dm_re && !c_dm_we && !c_im_re && !c_rf_we && !c_ar_we, "R10 unknown has no effect",
            {c_dm_re, c_dm_we, c_im_re, c_rf_we, c_ar_we}, 0);
        run(16'hF0F0, 16'h0, 0);
        chk(lat == 1 && !c_rf_we && !c_dm_we, "R10 second unknown", lat, 1);
        @(negedge clk);
        chk(!done && !dm_re && !dm_we && !im_re, "R11 strobes only in done cycle",
            {done, dm_re, dm_we, im_re}, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 16'(i * 16'h0101);
        hi0 = 8'h00;
        hi1 = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_paged();
        t_direct();
        t_store_imm();
        t_pointer();
        t_sat();
        t_imem();
        t_nop();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule